// File: doc/BRIEF.md
# Indexed Real-Time-Clock Register Port

This block is the host-facing register front end of a real-time clock. The host sees two byte addresses. Writing the even address chooses one of 128 byte locations; reading or writing the odd address then reaches the chosen location. Most locations are plain storage, for example the alarm bytes and the general-purpose battery RAM. Four locations are control registers with their own rules: a rate and oscillator register that holds a read-only update-in-progress bit, a mode and enable register, an interrupt flag register that clears itself when read, and a fixed read-only valid register.

The timekeeping logic sits outside this block. It signals the start and end of each once-per-second update, each periodic tick and each alarm match as single-cycle pulses. The block turns those pulses into flags and the interrupt line according to the enable bits. It hands the mode byte and the rate bits back to the timekeeping logic.

Top module: `rtc_regport`

## Requirements
- R1: A write with `bus_sel`=0 stores `bus_wdata & 0x7F` as the index. A read with `bus_sel`=0 returns 0xFF.
- R2: With `bus_sel`=1, every index other than 10, 11, 12 and 13 is plain byte storage. A read returns the last byte written to that index, and writes to one index leave every other index unchanged.
- R3: After a synchronous reset (`rst_n`=0 at a clock edge), index 10 reads 0x26, index 11 reads 0x02, index 12 reads 0x00, index 13 reads 0x80 and `irq` is 0. Reset therefore clears the periodic, alarm and square-wave enables and all flags, whatever their earlier values.
- R4: A write to index 10 replaces bits 6:0. Bit 7, the update-in-progress bit, keeps its value.
- R5: A `tk_upd_start` pulse sets index-10 bit 7 when index-11 bit 7 (set mode) is 0, and has no effect on it in set mode. A `tk_upd_done` pulse clears index-10 bit 7.
- R6: A write to index 11 with data bit 7 = 1 clears index-10 bit 7 and stores data bit 4 (update-interrupt enable) as 0. Other bits are stored as written.
- R7: Writes to index 12 and index 13 are ignored. Index 13 always reads 0x80.
- R8: A read of index 12 returns the flag byte. On that clock edge the byte becomes 0x00 and `irq` goes to 0.
- R9: Flag byte layout is bit 7 = any-interrupt, 6 = periodic, 5 = alarm, 4 = update-ended. The enable bits in index 11 are bit 6 = periodic, bit 5 = alarm, bit 4 = update. The effect of each event pulse is:
  - `tk_periodic` with bit 6 set raises flag bits 7 and 6.
  - `tk_alarm` with bit 5 set raises flag bits 7 and 5.
  - `tk_upd_done` always raises flag bit 4, and also raises bit 7 when bit 4 is set.
  - A periodic or alarm pulse whose enable is clear leaves the flags unchanged.
- R10: `irq` equals flag bit 7 and rises on the clock edge that takes the enabled event.
- R11: An event pulse in the same cycle as a read of index 12 is not lost. After that edge the flags hold only the new event's bits.
- R12: `mode_out` always shows the stored index-11 byte. `rate_out` shows index-10 bits 6:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Address bit: 0 = index port, 1 = data port |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the selected location |
| tk_upd_start | input | 1 | Pulse: once-per-second update begins |
| tk_upd_done | input | 1 | Pulse: update finished |
| tk_periodic | input | 1 | Pulse: periodic tick |
| tk_alarm | input | 1 | Pulse: alarm time matched |
| mode_out | output | 8 | Stored mode and enable byte for the timekeeping logic |
| rate_out | output | 7 | Oscillator and rate bits for the timekeeping logic |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench writes a distinct computed byte to all 128 indices and then reads them all back. A design that aliased indices, let control-register rules leak into storage, or stored writes to the read-only bytes would show a mismatch. Directed sequences target four cases:
- A write to index 10 while an update is in progress. A design that wrote the busy bit would drop it.
- Entering set mode with the update enable set. A design that kept the enable would read back bit 4 high.
- An enabled event that coincides with the clearing read of the flag byte. A design that let the clear win would lose the interrupt.
- A reset taken with every enable and flag set. This catches designs that reset only part of the state.

// File: rtl/rtc_regport_pkg.sv
// Package: shared constants for the indexed RTC register port.
// Assumes an 8-bit host data path; register indices and bit positions are
// fixed by the software view and must not move.
package rtc_regport_pkg;
    localparam int DATA_W = 8;

    localparam logic [6:0] IDX_RATE  = 7'd10;
    localparam logic [6:0] IDX_MODE  = 7'd11;
    localparam logic [6:0] IDX_FLAG  = 7'd12;
    localparam logic [6:0] IDX_VALID = 7'd13;

    // mode register bit positions
    localparam int M_SET  = 7;
    localparam int M_PIE  = 6;
    localparam int M_AIE  = 5;
    localparam int M_UIE  = 4;

    // rate register busy bit
    localparam int R_BUSY = 7;

    // flag register bit positions
    localparam int F_ANY  = 7;
    localparam int F_PER  = 6;
    localparam int F_ALM  = 5;
    localparam int F_UPD  = 4;

    localparam logic [DATA_W-1:0] RST_RATE  = 8'h26;
    localparam logic [DATA_W-1:0] RST_MODE  = 8'h02;
    localparam logic [DATA_W-1:0] RST_FLAG  = 8'h00;
    localparam logic [DATA_W-1:0] VALID_VAL = 8'h80;
    localparam logic [DATA_W-1:0] IDX_READ  = 8'hFF;
endpackage

// File: rtl/rtc_ctrl_bank.sv
// Module: rtc_ctrl_bank
// Holds the rate register (with its read-only busy bit) and the mode
// register. Assumes write strobes are already decoded by index and that
// timekeeping pulses last one cycle.
module rtc_ctrl_bank
    import rtc_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_rate,
    input  logic              wr_mode,
    input  logic [DATA_W-1:0] wdata,
    input  logic              upd_start,
    input  logic              upd_done,
    output logic [DATA_W-1:0] rate_q,
    output logic [DATA_W-1:0] mode_q
);
    logic busy_q;
    logic [DATA_W-2:0] rate_lo_q;
    logic [DATA_W-1:0] mode_wval;

    // Value stored on a mode write: entering set mode drops the update enable.
    always_comb begin
        mode_wval = wdata;
        if (wdata[M_SET]) mode_wval[M_UIE] = 1'b0;
    end

    // Rate bits 6:0: host-writable storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       rate_lo_q <= RST_RATE[DATA_W-2:0];
        else if (wr_rate) rate_lo_q <= wdata[DATA_W-2:0];
    end

    // Busy bit: set by update start outside set mode, cleared by update end or set mode entry.
    always_ff @(posedge clk) begin
        if (!rst_n)                          busy_q <= RST_RATE[R_BUSY];
        else if (wr_mode && wdata[M_SET])    busy_q <= 1'b0;
        else if (upd_done)                   busy_q <= 1'b0;
        else if (upd_start && !mode_q[M_SET]) busy_q <= 1'b1;
    end

    // Mode register storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= RST_MODE;
        else if (wr_mode) mode_q <= mode_wval;
    end

    assign rate_q = {busy_q, rate_lo_q};
endmodule

// File: rtl/rtc_flag_bank.sv
// Module: rtc_flag_bank
// Interrupt flag register and interrupt line. Flags are set by enabled
// events and cleared by a host read; a same-cycle event survives the clear.
module rtc_flag_bank
    import rtc_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_clear,
    input  logic              en_per,
    input  logic              en_alm,
    input  logic              en_upd,
    input  logic              ev_per,
    input  logic              ev_alm,
    input  logic              ev_upd,
    output logic [DATA_W-1:0] flag_q,
    output logic              irq
);
    logic [DATA_W-1:0] set_bits;
    logic [DATA_W-1:0] base;

    // Collect the flag bits raised by this cycle's events.
    always_comb begin
        set_bits = '0;
        if (ev_per && en_per) begin
            set_bits[F_PER] = 1'b1;
            set_bits[F_ANY] = 1'b1;
        end
        if (ev_alm && en_alm) begin
            set_bits[F_ALM] = 1'b1;
            set_bits[F_ANY] = 1'b1;
        end
        if (ev_upd) begin
            set_bits[F_UPD] = 1'b1;
            if (en_upd) set_bits[F_ANY] = 1'b1;
        end
        base = rd_clear ? '0 : flag_q;
    end

    // Flag storage: clear on read, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= RST_FLAG;
        else        flag_q <= base | set_bits;
    end

    assign irq = flag_q[F_ANY];
endmodule

// File: rtl/rtc_scratch_ram.sv
// Module: rtc_scratch_ram
// Plain byte storage for every index; the top suppresses writes to the
// control indices. Contents are not reset (battery-backed storage model).
module rtc_scratch_ram
    import rtc_regport_pkg::*;
#(
    parameter int IDX_W = 7,
    localparam int DEPTH = 1 << IDX_W
)(
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Byte write at the addressed location.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/rtc_regport.sv
// Module: rtc_regport (top)
// Two-address host port: even address holds the index, odd address reaches
// the indexed byte. Decodes the four control indices, muxes read data and
// forwards mode and rate bits to the timekeeping logic. Assumes one-cycle
// bus strobes.
module rtc_regport
    import rtc_regport_pkg::*;
#(
    parameter int IDX_W = 7
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tk_upd_start,
    input  logic              tk_upd_done,
    input  logic              tk_periodic,
    input  logic              tk_alarm,
    output logic [DATA_W-1:0] mode_out,
    output logic [DATA_W-2:0] rate_out,
    output logic              irq
);
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] rate_q, mode_q, flag_q, ram_rd;
    logic              hit_rate, hit_mode, hit_flag, hit_valid, hit_ctrl;
    logic              data_wr, data_rd;

    // Index register: low IDX_W bits of an even-address write.
    always_ff @(posedge clk) begin
        if (!rst_n)               idx_q <= '0;
        else if (bus_wr && !bus_sel) idx_q <= bus_wdata[IDX_W-1:0];
    end

    // Decode of the control indices.
    always_comb begin
        hit_rate  = (idx_q == IDX_RATE[IDX_W-1:0]);
        hit_mode  = (idx_q == IDX_MODE[IDX_W-1:0]);
        hit_flag  = (idx_q == IDX_FLAG[IDX_W-1:0]);
        hit_valid = (idx_q == IDX_VALID[IDX_W-1:0]);
        hit_ctrl  = hit_rate | hit_mode | hit_flag | hit_valid;
        data_wr   = bus_wr && bus_sel;
        data_rd   = bus_rd && bus_sel;
    end

    rtc_ctrl_bank u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_rate   (data_wr && hit_rate),
        .wr_mode   (data_wr && hit_mode),
        .wdata     (bus_wdata),
        .upd_start (tk_upd_start),
        .upd_done  (tk_upd_done),
        .rate_q    (rate_q),
        .mode_q    (mode_q)
    );

    rtc_flag_bank u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_clear (data_rd && hit_flag),
        .en_per   (mode_q[M_PIE]),
        .en_alm   (mode_q[M_AIE]),
        .en_upd   (mode_q[M_UIE]),
        .ev_per   (tk_periodic),
        .ev_alm   (tk_alarm),
        .ev_upd   (tk_upd_done),
        .flag_q   (flag_q),
        .irq      (irq)
    );

    rtc_scratch_ram #(.IDX_W(IDX_W)) u_ram (
        .clk   (clk),
        .we    (data_wr && !hit_ctrl),
        .addr  (idx_q),
        .wdata (bus_wdata),
        .rdata (ram_rd)
    );

    // Read data mux: index port reads all-ones, data port by index.
    always_comb begin
        if (!bus_sel)       bus_rdata = IDX_READ;
        else if (hit_rate)  bus_rdata = rate_q;
        else if (hit_mode)  bus_rdata = mode_q;
        else if (hit_flag)  bus_rdata = flag_q;
        else if (hit_valid) bus_rdata = VALID_VAL;
        else                bus_rdata = ram_rd;
    end

    assign mode_out = mode_q;
    assign rate_out = rate_q[DATA_W-2:0];
endmodule

// File: rtl/rtc_regport_chk.sv
// Module: rtc_regport_chk
// Property checker bound to rtc_regport; observes ports, the index and the
// busy bit only.
module rtc_regport_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       tk_upd_start,
    input logic       tk_upd_done,
    input logic       tk_periodic,
    input logic       tk_alarm,
    input logic [7:0] mode_out,
    input logic       irq,
    input logic [6:0] idx_q,
    input logic       busy
);
    a_r1_index_port_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |-> bus_rdata == 8'hFF);

    a_r4_busy_not_writable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel && idx_q == 7'd10 && !tk_upd_start && !tk_upd_done)
        |=> busy == $past(busy));

    a_r6_set_mode_drops_uie: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel && idx_q == 7'd11 && bus_wdata[7])
        |=> (!mode_out[4] && !busy));

    a_r7_valid_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && idx_q == 7'd13) |-> bus_rdata == 8'h80);

    a_r8_read_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_sel && idx_q == 7'd12 && !tk_periodic && !tk_alarm && !tk_upd_done)
        |=> !irq);

    a_r9_periodic_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (tk_periodic && mode_out[6]) |=> irq);
endmodule

bind rtc_regport rtc_regport_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .tk_upd_start (tk_upd_start),
    .tk_upd_done  (tk_upd_done),
    .tk_periodic  (tk_periodic),
    .tk_alarm     (tk_alarm),
    .mode_out     (mode_out),
    .irq          (irq),
    .idx_q        (idx_q),
    .busy         (rate_q[7])
);

// File: tb/rtc_regport_tb.sv
module rtc_regport_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tk_upd_start = 1'b0, tk_upd_done = 1'b0, tk_periodic = 1'b0, tk_alarm = 1'b0;
    logic [7:0] mode_out;
    logic [6:0] rate_out;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_regport u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tk_upd_start(tk_upd_start),
        .tk_upd_done(tk_upd_done), .tk_periodic(tk_periodic), .tk_alarm(tk_alarm),
        .mode_out(mode_out), .rate_out(rate_out), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    // one-cycle bus write
    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk); bus_sel = sel; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    // one-cycle bus read; data sampled before the edge
    task automatic rd(input logic sel, output logic [7:0] d);
        @(negedge clk); bus_sel = sel; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic rd_idx(input logic [6:0] i, output logic [7:0] d);
        wr(1'b0, {1'b0, i});
        rd(1'b1, d);
    endtask

    task automatic wr_idx(input logic [6:0] i, input logic [7:0] v);
        wr(1'b0, {1'b0, i});
        wr(1'b1, v);
    endtask

    // pulse selected event inputs for one cycle: {start, done, periodic, alarm}
    task automatic pulse(input logic [3:0] ev);
        @(negedge clk);
        {tk_upd_start, tk_upd_done, tk_periodic, tk_alarm} = ev;
        @(negedge clk);
        {tk_upd_start, tk_upd_done, tk_periodic, tk_alarm} = '0;
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 5) & 8'hFF);
    endfunction

    // expected readback after the sweep's write of pat(i), busy bit 0
    function automatic logic [7:0] sweep_exp(input int i);
        logic [7:0] p = pat(i);
        if (i == 10) return p & 8'h7F;
        if (i == 11) return p[7] ? (p & 8'hEF) : p;
        if (i == 12) return 8'h00;
        if (i == 13) return 8'h80;
        return p;
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        do_reset();

        // R3 reset values
        rd_idx(7'd10, d); chk("R3 rate reset", d, 8'h26);
        rd_idx(7'd11, d); chk("R3 mode reset", d, 8'h02);
        rd_idx(7'd12, d); chk("R3 flag reset", d, 8'h00);
        rd_idx(7'd13, d); chk("R3 valid reset", d, 8'h80);
        chk("R3 irq reset", {7'd0, irq}, 8'h00);
        chk("R12 mode_out reset", mode_out, 8'h02);
        chk("R12 rate_out reset", {1'b0, rate_out}, 8'h26);

        // R1 even-address read and index masking
        rd(1'b0, d); chk("R1 index port read", d, 8'hFF);
        wr_idx(7'd20, 8'h5A);
        wr(1'b0, 8'h94);               // 0x94 & 0x7F = 20
        rd(1'b1, d); chk("R1 index masked to 7 bits", d, 8'h5A);

        // R2/R7 full sweep: write all, then read all
        for (int i = 0; i < 128; i++) wr_idx(7'(i), pat(i));
        for (int i = 0; i < 128; i++) begin
            rd_idx(7'(i), d);
            chk($sformatf("R2 sweep idx %0d", i), d, sweep_exp(i));
        end
        chk("R12 mode_out after sweep", mode_out, sweep_exp(11));
        chk("R12 rate_out after sweep", {1'b0, rate_out}, sweep_exp(10));

        // R5/R4 busy bit
        do_reset();
        pulse(4'b1000);
        rd_idx(7'd10, d); chk("R5 busy set by update start", d, 8'hA6);
        wr_idx(7'd10, 8'h03);
        rd_idx(7'd10, d); chk("R4 busy kept on write", d, 8'h83);
        wr_idx(7'd10, 8'hFF);
        rd_idx(7'd10, d); chk("R4 busy not writable", d, 8'hFF);
        pulse(4'b0100);
        rd_idx(7'd10, d); chk("R5 busy cleared by update done", d, 8'h7F);
        rd_idx(7'd12, d); chk("R9 update flag without enable", d, 8'h10);
        chk("R10 no irq without update enable", {7'd0, irq}, 8'h00);

        // R6 set mode entry
        pulse(4'b1000);
        wr_idx(7'd11, 8'hFE);
        rd_idx(7'd11, d); chk("R6 set mode drops update enable", d, 8'hEE);
        rd_idx(7'd10, d); chk("R6 set mode clears busy", d, 8'h7F);
        chk("R12 mode_out follows", mode_out, 8'hEE);
        pulse(4'b1000);
        rd_idx(7'd10, d); chk("R5 no busy in set mode", d, 8'h7F);
        wr_idx(7'd11, 8'h12);
        rd_idx(7'd11, d); chk("R6 enable kept outside set mode", d, 8'h12);

        // R7 flag and valid registers ignore writes
        wr_idx(7'd12, 8'hFF);
        rd_idx(7'd12, d); chk("R7 flag write ignored", d, 8'h00);
        wr_idx(7'd13, 8'h00);
        rd_idx(7'd13, d); chk("R7 valid write ignored", d, 8'h80);

        // R9/R10/R8 event flags
        wr_idx(7'd11, 8'h02);
        pulse(4'b0011);
        chk("R9 disabled periodic/alarm no irq", {7'd0, irq}, 8'h00);
        rd_idx(7'd12, d); chk("R9 disabled events leave flags", d, 8'h00);
        wr_idx(7'd11, 8'h42);
        wr(1'b0, 8'h0C);
        pulse(4'b0010);
        chk("R10 irq after periodic", {7'd0, irq}, 8'h01);
        rd(1'b1, d); chk("R9 periodic flags", d, 8'hC0);
        chk("R8 irq dropped after read", {7'd0, irq}, 8'h00);
        rd(1'b1, d); chk("R8 flags cleared", d, 8'h00);
        wr_idx(7'd11, 8'h22);
        wr(1'b0, 8'h0C);
        pulse(4'b0001);
        rd(1'b1, d); chk("R9 alarm flags", d, 8'hA0);
        wr_idx(7'd11, 8'h12);
        wr(1'b0, 8'h0C);
        pulse(4'b0100);
        chk("R10 irq after update with enable", {7'd0, irq}, 8'h01);
        rd(1'b1, d); chk("R9 update flags with enable", d, 8'h90);

        // R11 event coinciding with the clearing read
        wr_idx(7'd11, 8'h42);
        wr(1'b0, 8'h0C);
        pulse(4'b0010);
        @(negedge clk); bus_sel = 1'b1; bus_rd = 1'b1; tk_periodic = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0; tk_periodic = 1'b0;
        chk("R11 read returns old flags", d, 8'hC0);
        chk("R11 irq survives clear", {7'd0, irq}, 8'h01);
        rd(1'b1, d); chk("R11 new event flags kept", d, 8'hC0);

        // R3 reset with everything enabled and pending
        wr_idx(7'd11, 8'h7E);
        pulse(4'b0111);
        chk("R3 irq before reset", {7'd0, irq}, 8'h01);
        do_reset();
        chk("R3 irq low after reset", {7'd0, irq}, 8'h00);
        rd_idx(7'd11, d); chk("R3 enables cleared by reset", d, 8'h02);
        rd_idx(7'd12, d); chk("R3 flags cleared by reset", d, 8'h00);

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule